// File: doc/BRIEF.md
# Mapped Serial-Flash Read Port

This block lets on-chip bus masters read an external serial flash as if it were ordinary read-only memory. A read that lands in the mapped window is translated into a read frame request to a separate command sequencer. The sequencer streams back consecutive words starting at the requested address. The port keeps those words in a small FIFO, so a master walking linearly through the flash is usually served from buffered data after a single cycle.

Any access that the window cannot serve is answered locally with an error response and never reaches the sequencer. This covers writes, accesses while the controller is switched off, accesses while the mapped mode is not selected, and addresses beyond the configured flash size. The block also gates the data-register read path: that path returns zero while the mapped mode is selected.

Top module: `xip_read_port`

## Requirements
- R1: The window is live only when `cfg_enable` is 1 and `cfg_fmode` equals 2'b11. In every other case a bus access completes with `bus_ready` and `bus_err` both high and `bus_rdata` zero.
- R2: A bus write (`bus_write`=1) always completes with an error response. It raises no `seq_req` and leaves the prefetch contents and the expected next address unchanged.
- R3: An address is in range when `bus_addr >> (cfg_fsize+1)` is zero, so the flash size is 2^(cfg_fsize+1) bytes. Any other address gets an error response.
- R4: A miss flushes the FIFO and pulses `seq_stop` for one cycle if a frame is running. It then holds `seq_req` with `seq_addr` equal to the requested address until `seq_ack`. The answer is the first word delivered after the acknowledge.
- R5: A hit occurs when the address equals the previously served address plus 4 and the FIFO is not empty. The word is served from the FIFO, `bus_ready` rises on the first clock edge after the request is presented, and no sequencer request is made.
- R6: While DEPTH words are buffered, `seq_rready` is low and the sequencer stream pauses. It resumes once a word is consumed.
- R7: Leaving the live state while a frame runs pulses `seq_stop` and flushes the FIFO. The first access after re-entry is therefore a miss.
- R8: `dreg_rdata` is zero whenever `cfg_fmode` is 2'b11. Otherwise it equals `ind_word`.
- R9: `bus_ready` is a single-cycle pulse. Each pulse answers a request that was presented, and one request is outstanding at a time.
- R10: Error responses arrive on the first clock edge after the request is presented and carry zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Controller enable |
| cfg_fmode | input | 2 | Functional mode select; 2'b11 selects mapped reads |
| cfg_fsize | input | SIZE_W | Flash size code: size is 2^(code+1) bytes |
| bus_valid | input | 1 | Bus request present; held until bus_ready |
| bus_write | input | 1 | Request is a write |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_ready | output | 1 | Request completed (one-cycle pulse) |
| bus_err | output | 1 | Completion is an error response |
| bus_rdata | output | DW | Read data |
| seq_req | output | 1 | Start a read frame |
| seq_addr | output | ADDR_W | Frame start address |
| seq_ack | input | 1 | Sequencer accepted the frame start |
| seq_stop | output | 1 | Abort the running frame |
| seq_rvalid | input | 1 | Streamed word valid |
| seq_rdata | input | DW | Streamed word |
| seq_rready | output | 1 | Port can accept a streamed word |
| ind_word | input | DW | Data-register value from the non-mapped path |
| dreg_rdata | output | DW | Data-register read value |

## Verification
Two events can fall into the same cycle. A streamed word can arrive in the cycle where a miss flushes the FIFO, and a word can be consumed in the cycle where the full FIFO lets the stream resume. The bench provokes the first case by jumping to a non-sequential address while the sequencer model streams continuously. It provokes the second by reading the next sequential word while the FIFO holds DEPTH words. In the first case, the data returned after the flush must be the word of the new address. In the second, the model's count of accepted words must grow by exactly one per consumed word.

// File: rtl/xip_pkg.sv
package xip_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_WAIT   = 2'd2,
        ST_RESP   = 2'd3
    } xip_state_e;

    localparam logic [1:0] FMODE_MAPPED = 2'b11;
endpackage

// File: rtl/xip_access_check.sv
module xip_access_check #(
    parameter int ADDR_W = 24,
    parameter int SIZE_W = 5
) (
    input  logic              cfg_enable,
    input  logic [1:0]        cfg_fmode,
    input  logic [SIZE_W-1:0] cfg_fsize,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              mapped_on,
    output logic              acc_err
);
    import xip_pkg::*;

    logic [SIZE_W:0] shamt;
    logic            out_of_range;

    always_comb begin
        shamt        = {1'b0, cfg_fsize} + (SIZE_W+1)'(1);
        out_of_range = ((acc_addr >> shamt) != '0);
        mapped_on    = cfg_enable && (cfg_fmode == FMODE_MAPPED);
        acc_err      = acc_write || !mapped_on || out_of_range;
    end
endmodule

// File: rtl/xip_prefetch_fifo.sv
module xip_prefetch_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic          empty,
    output logic          full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t      q, d;
    logic [DW-1:0] mem_q [DEPTH];
    logic          do_push, do_pop;

    assign empty = (q.cnt == '0);
    assign full  = (q.cnt == CW'(DEPTH));
    assign rdata = mem_q[q.rd];

    always_comb begin
        d       = q;
        do_push = push && !full && !flush;
        do_pop  = pop && !empty && !flush;
        if (flush) begin
            d = '0;
        end else begin
            if (do_push)
                d.wr = (q.wr == PW'(DEPTH-1)) ? '0 : q.wr + PW'(1);
            if (do_pop)
                d.rd = (q.rd == PW'(DEPTH-1)) ? '0 : q.rd + PW'(1);
            case ({do_push, do_pop})
                2'b10:   d.cnt = q.cnt + CW'(1);
                2'b01:   d.cnt = q.cnt - CW'(1);
                default: d.cnt = q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (do_push && (q.wr == PW'(i)))
                mem_q[i] <= wdata;
        end
    end
endmodule

// File: rtl/xip_read_port.sv
module xip_read_port #(
    parameter int ADDR_W = 24,
    parameter int DW     = 32,
    parameter int DEPTH  = 8,
    parameter int SIZE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic [1:0]        cfg_fmode,
    input  logic [SIZE_W-1:0] cfg_fsize,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              bus_ready,
    output logic              bus_err,
    output logic [DW-1:0]     bus_rdata,
    output logic              seq_req,
    output logic [ADDR_W-1:0] seq_addr,
    input  logic              seq_ack,
    output logic              seq_stop,
    input  logic              seq_rvalid,
    input  logic [DW-1:0]     seq_rdata,
    output logic              seq_rready,
    input  logic [DW-1:0]     ind_word,
    output logic [DW-1:0]     dreg_rdata
);
    import xip_pkg::*;

    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(DW / 8);

    typedef struct packed {
        xip_state_e        state;
        logic [ADDR_W-1:0] next_addr;
        logic              active;
        logic [DW-1:0]     rdata;
        logic              ready;
        logic              err;
    } port_st_t;

    port_st_t      q, d;
    logic          mapped_on, acc_err;
    logic          fifo_flush, fifo_pop, fifo_push;
    logic          fifo_empty, fifo_full;
    logic [DW-1:0] fifo_rdata;
    logic          stop_w;
    logic          hit;

    xip_access_check #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_check (
        .cfg_enable (cfg_enable),
        .cfg_fmode  (cfg_fmode),
        .cfg_fsize  (cfg_fsize),
        .acc_write  (bus_write),
        .acc_addr   (bus_addr),
        .mapped_on  (mapped_on),
        .acc_err    (acc_err)
    );

    xip_prefetch_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (fifo_flush),
        .push  (fifo_push),
        .wdata (seq_rdata),
        .pop   (fifo_pop),
        .rdata (fifo_rdata),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    assign hit = (bus_addr == q.next_addr) && !fifo_empty;

    always_comb begin
        d          = q;
        d.ready    = 1'b0;
        d.err      = 1'b0;
        fifo_flush = 1'b0;
        fifo_pop   = 1'b0;
        stop_w     = 1'b0;

        // leaving the live state kills a running frame
        if (!mapped_on && q.active) begin
            stop_w     = 1'b1;
            fifo_flush = 1'b1;
            d.active   = 1'b0;
        end

        case (q.state)
            ST_IDLE: begin
                if (bus_valid) begin
                    if (acc_err) begin
                        d.err   = 1'b1;
                        d.ready = 1'b1;
                        d.rdata = '0;
                        d.state = ST_RESP;
                    end else if (hit) begin
                        fifo_pop    = 1'b1;
                        d.rdata     = fifo_rdata;
                        d.ready     = 1'b1;
                        d.next_addr = q.next_addr + WORD_STEP;
                        d.state     = ST_RESP;
                    end else begin
                        fifo_flush  = 1'b1;
                        stop_w      = q.active;
                        d.active    = 1'b0;
                        d.next_addr = bus_addr;
                        d.state     = ST_LAUNCH;
                    end
                end
            end
            ST_LAUNCH: begin
                if (seq_ack) begin
                    d.active = 1'b1;
                    d.state  = ST_WAIT;
                end else if (!mapped_on) begin
                    d.err   = 1'b1;
                    d.ready = 1'b1;
                    d.rdata = '0;
                    d.state = ST_RESP;
                end
            end
            ST_WAIT: begin
                if (!mapped_on) begin
                    d.err   = 1'b1;
                    d.ready = 1'b1;
                    d.rdata = '0;
                    d.state = ST_RESP;
                end else if (!fifo_empty) begin
                    fifo_pop    = 1'b1;
                    d.rdata     = fifo_rdata;
                    d.ready     = 1'b1;
                    d.next_addr = q.next_addr + WORD_STEP;
                    d.state     = ST_RESP;
                end
            end
            default: begin
                d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign fifo_push  = seq_rvalid && seq_rready;
    assign seq_rready = q.active && !fifo_full && !fifo_flush;
    assign seq_req    = (q.state == ST_LAUNCH);
    assign seq_addr   = q.next_addr;
    assign seq_stop   = stop_w;
    assign bus_ready  = q.ready;
    assign bus_err    = q.err;
    assign bus_rdata  = q.rdata;
    assign dreg_rdata = (cfg_fmode == FMODE_MAPPED) ? '0 : ind_word;
endmodule

// File: rtl/xip_read_port_chk.sv
module xip_read_port_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_enable,
    input logic [1:0]    cfg_fmode,
    input logic          bus_valid,
    input logic          bus_write,
    input logic          bus_ready,
    input logic          bus_err,
    input logic [DW-1:0] bus_rdata,
    input logic          seq_req,
    input logic          seq_stop
);
    p_ready_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);

    p_answers_request_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |-> $past(bus_valid));

    p_err_zero_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_ready && (bus_rdata == '0)));

    p_write_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ready && bus_write) |-> bus_err);

    p_unmapped_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ready && !$past(cfg_enable && (cfg_fmode == 2'b11))) |-> bus_err);

    p_stop_req_apart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(seq_stop && seq_req));
endmodule

bind xip_read_port xip_read_port_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_enable (cfg_enable),
    .cfg_fmode  (cfg_fmode),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_ready  (bus_ready),
    .bus_err    (bus_err),
    .bus_rdata  (bus_rdata),
    .seq_req    (seq_req),
    .seq_stop   (seq_stop)
);

// File: tb/xip_read_port_test.sv
`timescale 1ns/1ps
module xip_read_port_test;
    localparam int AW = 12;
    localparam int DW = 32;
    localparam int DEPTH = 4;
    localparam int SW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_enable = 1'b0;
    logic [1:0]    cfg_fmode = 2'b00;
    logic [SW-1:0] cfg_fsize = '0;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_ready, bus_err;
    logic [DW-1:0] bus_rdata;
    logic          seq_req, seq_stop, seq_rready;
    logic [AW-1:0] seq_addr;
    logic          seq_ack;
    logic          seq_rvalid;
    logic [DW-1:0] seq_rdata;
    logic [DW-1:0] ind_word = 32'hCAFE_0001;
    logic [DW-1:0] dreg_rdata;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    xip_read_port #(.ADDR_W(AW), .DW(DW), .DEPTH(DEPTH), .SIZE_W(SW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_fmode(cfg_fmode),
        .cfg_fsize(cfg_fsize), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_ready(bus_ready), .bus_err(bus_err),
        .bus_rdata(bus_rdata), .seq_req(seq_req), .seq_addr(seq_addr),
        .seq_ack(seq_ack), .seq_stop(seq_stop), .seq_rvalid(seq_rvalid),
        .seq_rdata(seq_rdata), .seq_rready(seq_rready), .ind_word(ind_word),
        .dreg_rdata(dreg_rdata)
    );

    function automatic logic [DW-1:0] flash_word(input logic [AW-1:0] a);
        return ({20'h0, a} * 32'h9E37_79B1) + 32'h1234_5678;
    endfunction

    // sequencer model
    logic          m_active;
    logic [AW-1:0] m_ptr;
    int            m_acc, m_reqs, m_stops, cyc;
    bit            gap_on = 1'b0;

    assign seq_rvalid = m_active && (!gap_on || cyc[0]);
    assign seq_rdata  = flash_word(m_ptr);

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_active <= 1'b0; m_ptr <= '0; m_acc <= 0; m_reqs <= 0;
            m_stops <= 0; cyc <= 0; seq_ack <= 1'b0;
        end else begin
            cyc     <= cyc + 1;
            seq_ack <= 1'b0;
            if (seq_stop) begin
                m_active <= 1'b0;
                m_stops  <= m_stops + 1;
            end
            if (seq_req && !seq_ack) begin
                seq_ack  <= 1'b1;
                m_ptr    <= seq_addr;
                m_active <= 1'b1;
                m_reqs   <= m_reqs + 1;
                m_acc    <= 0;
            end else if (seq_rvalid && seq_rready) begin
                m_ptr <= m_ptr + AW'(4);
                m_acc <= m_acc + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic bus_op(input logic wr, input logic [AW-1:0] a,
                          output logic [DW-1:0] dat, output logic er, output int lat);
        tick(1);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a;
        lat = 0;
        for (int i = 0; i < 300; i++) begin
            @(posedge clk); #1;
            lat++;
            if (bus_ready) break;
        end
        dat = bus_rdata; er = bus_err;
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic read_expect(input logic [AW-1:0] a, input bit exp_err, input string req);
        logic [DW-1:0] dat; logic er; int lat;
        bus_op(1'b0, a, dat, er, lat);
        chk(er == exp_err, req, {31'd0, er}, {31'd0, exp_err});
        if (exp_err) chk(dat == '0 && lat == 1, "R10", dat, 0);
        else         chk(dat == flash_word(a), req, dat, flash_word(a));
    endtask

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [DW-1:0] dat; logic er; int lat; int r0;
        tick(3);
        // reset state
        chk(bus_ready == 0 && bus_err == 0, "R9 reset", {30'd0, bus_ready, bus_err}, 0);
        chk(seq_req == 0 && seq_rready == 0 && seq_stop == 0, "R4 reset",
            {29'd0, seq_req, seq_rready, seq_stop}, 0);
        rst_n = 1'b1;
        cfg_enable = 1'b1; cfg_fmode = 2'b11; cfg_fsize = 5'd12;
        tick(2);

        // R4 first miss
        bus_op(1'b0, 12'h040, dat, er, lat);
        chk(dat == flash_word(12'h040) && !er, "R4 miss data", dat, flash_word(12'h040));
        chk(m_reqs == 1 && lat > 1, "R4 request issued", m_reqs, 1);

        // R6 fill and pause
        tick(30);
        chk(m_acc == DEPTH + 1, "R6 pause at full", m_acc, DEPTH + 1);
        chk(seq_rready == 0, "R6 rready low", {31'd0, seq_rready}, 0);

        // R5 hit, concurrent consume/resume
        bus_op(1'b0, 12'h044, dat, er, lat);
        chk(lat == 1, "R5 hit latency", lat, 1);
        chk(dat == flash_word(12'h044), "R5 hit data", dat, flash_word(12'h044));
        chk(m_reqs == 1, "R5 no request", m_reqs, 1);
        tick(10);
        chk(m_acc == DEPTH + 2, "R6 resume", m_acc, DEPTH + 2);

        // R2 write ignored
        bus_op(1'b1, 12'h048, dat, er, lat);
        chk(er == 1 && lat == 1 && dat == 0, "R2 write error", {31'd0, er}, 1);
        chk(m_reqs == 1, "R2 no request", m_reqs, 1);
        bus_op(1'b0, 12'h048, dat, er, lat);
        chk(lat == 1 && dat == flash_word(12'h048), "R2 prefetch kept", dat, flash_word(12'h048));

        // R4 miss while a frame runs (flush coincides with stream)
        bus_op(1'b0, 12'h200, dat, er, lat);
        chk(m_stops == 1 && m_reqs == 2, "R4 stop then request", m_stops, 1);
        chk(dat == flash_word(12'h200), "R4 flushed data", dat, flash_word(12'h200));

        // R7 leave mode mid-frame
        tick(20);
        cfg_enable = 1'b0;
        tick(3);
        chk(m_stops == 2, "R7 stop on disable", m_stops, 2);
        cfg_enable = 1'b1;
        bus_op(1'b0, 12'h204, dat, er, lat);
        chk(lat > 1 && m_reqs == 3, "R7 miss after re-entry", m_reqs, 3);
        chk(dat == flash_word(12'h204), "R7 data", dat, flash_word(12'h204));

        // R1 / R8 mode sweep
        for (int en = 0; en < 2; en++) begin
            for (int md = 0; md < 4; md++) begin
                cfg_enable = en[0]; cfg_fmode = md[1:0];
                tick(1);
                chk(dreg_rdata == ((md == 3) ? 32'd0 : ind_word), "R8 data register",
                    dreg_rdata, (md == 3) ? 32'd0 : ind_word);
                read_expect(12'h008, !(en == 1 && md == 3), "R1 mode gate");
            end
        end

        // R3 range sweep
        cfg_enable = 1'b1; cfg_fmode = 2'b11;
        for (int fs = 0; fs < 13; fs++) begin
            int lim;
            cfg_fsize = fs[4:0];
            lim = 1 << (fs + 1);
            for (int k = 0; k < 4; k++) begin
                int a;
                a = (k == 0) ? 0 : (k == 1) ? 4 : (k == 2) ? lim - 4 : lim;
                if (a >= 0 && a < 4096)
                    read_expect(AW'(a), ((a >> (fs + 1)) != 0), "R3 range");
            end
        end

        // R5 sequential sweep with gaps, then strided misses
        cfg_fsize = 5'd12;
        gap_on = 1'b1;
        r0 = m_reqs;
        for (int i = 0; i < 40; i++) read_expect(AW'(12'h100 + 4 * i), 1'b0, "R5 linear");
        chk(m_reqs == r0 + 1, "R5 single frame for linear run", m_reqs, r0 + 1);
        for (int i = 0; i < 20; i++) read_expect(AW'(12'h800 + 8 * i), 1'b0, "R4 strided");
        chk(m_reqs == r0 + 21, "R4 one frame per miss", m_reqs, r0 + 21);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule